// File: doc/BRIEF.md
# Panel Signal Formatter with Bypass

This block sits between a generic TFT display controller and the panel pins. It has two modes, picked at run time by one bit that software writes over APB. In pass-through mode the controller's pixel data, syncs and data-enable reach the pins unchanged and without delay. In formatting mode the same signals are captured on the falling edge of the output clock. The block also builds three panel control strobes: a source-driver start pulse once per line, a gate clock pulse once per line, and a polarity-enable signal (MOD).

The start pulse and gate pulse each have a programmable delay and width, counted in output clocks from the start of active data. MOD stays low after the controller enable rises. It goes high only after a programmable number of start-pulse rising edges, and a control bit can force it high. Software first sets the mode, then loads the two timing words, then raises the controller enable. The block captures the timing words at that rising edge of the enable.

Top module: `panel_fmt`

## Requirements
- R1: When MODE (bit 0 of the mode word at offset 0x000) is 0, pan_data, pan_hsync, pan_vsync and pan_de equal the matching lcd_* inputs combinationally, and pan_sps, pan_gclk and pan_mod are held at 0.
- R2: When MODE is 1, pan_data and the sync/enable outputs take the input values present at each falling edge of clk and keep them until the next falling edge.
- R3: Four 16-bit read/write words sit at offsets 0x000 (mode, reset 0x000C), 0x004 (control, reset 0x0000), 0x008 (timing A, reset 0x1000) and 0x00C (timing B, reset 0x0000). A read returns the stored value zero-extended to 32 bits, and PREADY is always 1.
- R4: For an access at an offset from 0x010 to 0xFFF, prdata is 0 and PSLVERR is 1 in the access phase, and a write there changes no word.
- R5: Timing A bits [5:0]=D and [11:6]=W. In formatting mode, pan_sps is high for exactly W clocks, starting D+1 clocks after pan_de rises. W=0 gives no pulse.
- R6: Timing B bits [5:0]=D and [11:6]=W shape pan_gclk by the same rule as R5.
- R7: Timing A bits [15:12]=M. After lcd_en rises, pan_mod first goes high one clock after the (M+1)-th rising edge of pan_sps. The reset value gives 2 edges.
- R8: While lcd_en is 1 in formatting mode, control bit 0 set to 1 forces pan_mod high at the next falling edge, whatever the edge count.
- R9: When lcd_en is 0, pan_mod is 0 from the next falling edge on, and the edge count restarts from zero at the next enable.
- R10: The timing fields are captured when lcd_en rises. Writes to the timing words while lcd_en stays high do not change the pulses until lcd_en rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | APB clock, also the pixel and output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | AW | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error for the reserved range |
| lcd_en | input | 1 | Display controller enable |
| lcd_data | input | DW | Controller pixel data |
| lcd_hsync | input | 1 | Controller line sync |
| lcd_vsync | input | 1 | Controller frame sync |
| lcd_de | input | 1 | Controller active-data enable |
| pan_clk | output | 1 | Output clock to the panel |
| pan_data | output | DW | Panel pixel data |
| pan_hsync | output | 1 | Panel line sync |
| pan_vsync | output | 1 | Panel frame sync |
| pan_de | output | 1 | Panel data enable |
| pan_sps | output | 1 | Source-driver start pulse |
| pan_gclk | output | 1 | Gate clock pulse |
| pan_mod | output | 1 | Polarity enable |

## Verification
The bench checks that MOD's first rise comes after exactly the programmed number of start-pulse edges for three counts. An off-by-one counter would release MOD one line early or late. It shapes lines with the start pulse and gate pulse at different settings and compares every cycle. A wrong delay origin would show up as a pulse shifted by one clock. It writes to a reserved offset whose low bits alias the mode word; an incomplete address decode would switch the mode. It also rewrites the timing while enabled and drops the enable after MOD has risen. A design that took timing values live, or did not clear its edge count, would give the wrong pulse shape or a MOD that comes back too soon.

// File: rtl/panel_fmt.sv
module panel_fmt #(
  parameter int DW = 18,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          pready,
  output logic          pslverr,
  input  logic          lcd_en,
  input  logic [DW-1:0] lcd_data,
  input  logic          lcd_hsync,
  input  logic          lcd_vsync,
  input  logic          lcd_de,
  output logic          pan_clk,
  output logic [DW-1:0] pan_data,
  output logic          pan_hsync,
  output logic          pan_vsync,
  output logic          pan_de,
  output logic          pan_sps,
  output logic          pan_gclk,
  output logic          pan_mod
);
  localparam int FW = 6;
  localparam int CW = FW + 1;
  localparam int NW = 5;

  logic [15:0] setup_q, ctrl_q, tim1_q, tim2_q;
  logic [FW-1:0] sps_d, sps_w, gck_d, gck_w;
  logic [NW-1:0] mod_n, mod_cnt;
  logic [CW-1:0] cnt;
  logic en_q, de_q, sps_q;
  logic f_hs, f_vs, f_de, f_sps, f_gck, f_mod;
  logic [DW-1:0] f_data;

  wire rsvd = |paddr[AW-1:4];
  wire wr   = psel & penable & pwrite & ~rsvd;
  wire fmt  = setup_q[0];

  assign pready  = 1'b1;
  assign pslverr = psel & penable & rsvd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      setup_q <= 16'h000C;
      ctrl_q  <= 16'h0000;
      tim1_q  <= 16'h1000;
      tim2_q  <= 16'h0000;
    end else if (wr) begin
      case (paddr[3:2])
        2'd0: setup_q <= pwdata[15:0];
        2'd1: ctrl_q  <= pwdata[15:0];
        2'd2: tim1_q  <= pwdata[15:0];
        default: tim2_q <= pwdata[15:0];
      endcase
    end

  always_comb begin
    prdata = '0;
    if (psel && !rsvd)
      case (paddr[3:2])
        2'd0: prdata[15:0] = setup_q;
        2'd1: prdata[15:0] = ctrl_q;
        2'd2: prdata[15:0] = tim1_q;
        default: prdata[15:0] = tim2_q;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q  <= 1'b0;
      sps_d <= '0; sps_w <= '0; gck_d <= '0; gck_w <= '0;
      mod_n <= NW'(2);
    end else begin
      en_q <= lcd_en;
      if (lcd_en && !en_q) begin
        sps_d <= tim1_q[FW-1:0];
        sps_w <= tim1_q[2*FW-1:FW];
        gck_d <= tim2_q[FW-1:0];
        gck_w <= tim2_q[2*FW-1:FW];
        mod_n <= {1'b0, tim1_q[15:12]} + NW'(1);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      de_q <= 1'b0;
      cnt  <= '1;
    end else begin
      de_q <= lcd_de;
      if (lcd_de && !de_q) cnt <= '0;
      else if (cnt != '1) cnt <= cnt + CW'(1);
    end

  wire in_sps = (cnt >= {1'b0, sps_d}) && (cnt < ({1'b0, sps_d} + {1'b0, sps_w}));
  wire in_gck = (cnt >= {1'b0, gck_d}) && (cnt < ({1'b0, gck_d} + {1'b0, gck_w}));
  wire sps_int = en_q & fmt & in_sps;
  wire gck_int = en_q & fmt & in_gck;
  wire mod_int = lcd_en & (ctrl_q[0] | (mod_cnt >= mod_n));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sps_q   <= 1'b0;
      mod_cnt <= '0;
    end else begin
      sps_q <= sps_int;
      if (!lcd_en) mod_cnt <= '0;
      else if (sps_int && !sps_q && mod_cnt != '1) mod_cnt <= mod_cnt + NW'(1);
    end

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      f_data <= '0;
      {f_hs, f_vs, f_de, f_sps, f_gck, f_mod} <= '0;
    end else begin
      f_data <= lcd_data;
      f_hs   <= lcd_hsync;
      f_vs   <= lcd_vsync;
      f_de   <= lcd_de;
      f_sps  <= sps_int;
      f_gck  <= gck_int;
      f_mod  <= mod_int;
    end

  assign pan_clk   = clk;
  assign pan_data  = fmt ? f_data : lcd_data;
  assign pan_hsync = fmt ? f_hs : lcd_hsync;
  assign pan_vsync = fmt ? f_vs : lcd_vsync;
  assign pan_de    = fmt ? f_de : lcd_de;
  assign pan_sps   = fmt & f_sps;
  assign pan_gclk  = fmt & f_gck;
  assign pan_mod   = fmt & f_mod;

  wire unused_bits = ^{setup_q[15:1], ctrl_q[15:1], tim2_q[15:12], paddr[1:0], pwdata[31:16]};
endmodule

// File: rtl/panel_fmt_chk.sv
module panel_fmt_chk #(
  parameter int DW = 18,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          psel,
  input logic          penable,
  input logic [AW-1:0] paddr,
  input logic [31:0]   prdata,
  input logic          pslverr,
  input logic          lcd_en,
  input logic [DW-1:0] lcd_data,
  input logic [DW-1:0] pan_data,
  input logic          pan_sps,
  input logic          pan_gclk,
  input logic          pan_mod,
  input logic          fmt,
  input logic          force_mod
);
  AST_BYPASS_STROBES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt |-> (!pan_sps && !pan_gclk && !pan_mod)); // R1

  AST_FMT_FALLING_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt && $past(fmt)) |-> (pan_data == lcd_data)); // R2

  AST_RESERVED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && (|paddr[AW-1:4])) |-> (pslverr && prdata == 32'd0)); // R4

  AST_FORCE_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt && lcd_en && force_mod) |-> pan_mod); // R8

  AST_DISABLE_MOD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_en |-> !pan_mod); // R9
endmodule

bind panel_fmt panel_fmt_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .paddr(paddr),
  .prdata(prdata), .pslverr(pslverr), .lcd_en(lcd_en), .lcd_data(lcd_data),
  .pan_data(pan_data), .pan_sps(pan_sps), .pan_gclk(pan_gclk), .pan_mod(pan_mod),
  .fmt(setup_q[0]), .force_mod(ctrl_q[0])
);

// File: tb/test_panel_fmt.sv
`timescale 1ns/100ps
module test_panel_fmt;
  localparam int DW = 18;
  localparam int AW = 12;
  localparam int LINE = 50;
  localparam int ACT = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr;
  logic lcd_en = 0, lcd_hsync = 0, lcd_vsync = 0, lcd_de = 0;
  logic [DW-1:0] lcd_data = '0;
  logic pan_clk, pan_hsync, pan_vsync, pan_de, pan_sps, pan_gclk, pan_mod;
  logic [DW-1:0] pan_data;

  int n_chk = 0, n_fail = 0;
  bit fmt_exp = 0;
  bit sps_s[LINE], gck_s[LINE];
  bit sps_prev, mod_prev;
  int sps_rises, mod_rises, mod_at, byp_bad;

  always #2 clk = ~clk;

  panel_fmt #(.DW(DW), .AW(AW)) i_panel_fmt (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(posedge clk); #1 psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(posedge clk); #1 penable = 1;
    @(posedge clk); #1 psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [AW-1:0] a, output logic [31:0] d, output logic err);
    @(posedge clk); #1 psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(posedge clk); #1 penable = 1;
    #0.5 d = prdata; err = pslverr;
    @(posedge clk); #1 psel = 0; penable = 0;
  endtask

  task automatic set_en(input bit v);
    @(posedge clk); #1 lcd_en = v;
    repeat (3) @(posedge clk);
  endtask

  task automatic clear_track();
    sps_prev = pan_sps; mod_prev = pan_mod;
    sps_rises = 0; mod_rises = 0; mod_at = -1;
  endtask

  task automatic run_line(input int seed);
    for (int i = 0; i < LINE; i++) begin
      @(posedge clk); #1;
      lcd_de = (i < ACT);
      lcd_data = DW'(i * 7 + seed * 131);
      lcd_hsync = (i >= ACT + 2 && i < ACT + 5);
      lcd_vsync = (seed % 3 == 0) && (i > ACT);
      #0.5;
      if (!fmt_exp && (pan_data !== lcd_data || pan_de !== lcd_de || pan_hsync !== lcd_hsync
          || pan_vsync !== lcd_vsync || pan_sps || pan_gclk || pan_mod)) byp_bad++;
      @(negedge clk); #1;
      sps_s[i] = pan_sps; gck_s[i] = pan_gclk;
      if (pan_sps && !sps_prev) sps_rises++;
      if (pan_mod && !mod_prev) begin mod_rises++; if (mod_at < 0) mod_at = sps_rises; end
      sps_prev = pan_sps; mod_prev = pan_mod;
    end
  endtask

  task automatic check_shape(input string req, input bit gate, input int d, input int w);
    int bad = 0;
    for (int i = 0; i < LINE; i++) begin
      bit e = (i >= d + 1) && (i < d + 1 + w);
      if ((gate ? gck_s[i] : sps_s[i]) != e) bad++;
    end
    chk(req, bad, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    apb_read(12'h000, d, e); chk("R3 setup reset", d, 32'h000C);
    apb_read(12'h004, d, e); chk("R3 ctrl reset", d, 32'h0000);
    apb_read(12'h008, d, e); chk("R3 timing A reset", d, 32'h1000);
    apb_read(12'h00C, d, e); chk("R3 timing B reset", d, 32'h0000);
    chk("R3 pready", pready, 1);
    chk("R1 reset strobes low", {pan_sps, pan_gclk, pan_mod}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d; logic e;
    apb_write(12'h004, 32'hFFFF_A5A4); apb_read(12'h004, d, e); chk("R3 ctrl rw", d, 32'h0000_A5A4);
    chk("R3 no error on valid", e, 0);
    apb_write(12'h00C, 32'h0000_5A5A); apb_read(12'h00C, d, e); chk("R3 timing B rw", d, 32'h5A5A);
    apb_write(12'h004, 32'h0); apb_write(12'h00C, 32'h0);
  endtask

  task automatic t_reserved();
    logic [31:0] d; logic e;
    apb_write(12'h010, 32'h0000_FFFF);
    apb_read(12'h000, d, e); chk("R4 aliased write ignored", d, 32'h000C);
    apb_read(12'h010, d, e); chk("R4 reserved reads zero", d, 0); chk("R4 reserved pslverr", e, 1);
    apb_read(12'hFFC, d, e); chk("R4 top reserved pslverr", e, 1);
  endtask

  task automatic t_bypass();
    fmt_exp = 0; byp_bad = 0;
    apb_write(12'h008, 32'h1000 | 3 | (4 << 6));
    set_en(1);
    run_line(1); run_line(2);
    chk("R1 bypass pass-through and strobes low", byp_bad, 0);
    set_en(0);
  endtask

  task automatic t_retime();
    apb_write(12'h000, 32'h000D); fmt_exp = 1;
    @(posedge clk); #1 lcd_data = DW'(18'h1234);
    @(negedge clk); #1;
    @(posedge clk); #1 lcd_data = DW'(18'h2BCDE);
    #0.5 chk("R2 holds before falling edge", pan_data, 18'h1234);
    @(negedge clk); #1 chk("R2 updates at falling edge", pan_data, 18'h2BCDE);
  endtask

  task automatic t_shapes();
    apb_write(12'h008, 32'h1000 | 3 | (4 << 6));
    apb_write(12'h00C, 32'h0 | 7 | (2 << 6));
    set_en(1); run_line(4); run_line(5);
    check_shape("R5 sps d3 w4", 0, 3, 4);
    check_shape("R6 gclk d7 w2", 1, 7, 2);
    set_en(0);
    apb_write(12'h008, 32'h1000 | 0 | (1 << 6));
    apb_write(12'h00C, 32'h0 | 10 | (0 << 6));
    set_en(1); run_line(6); run_line(7);
    check_shape("R5 sps d0 w1", 0, 0, 1);
    check_shape("R6 gclk width zero", 1, 10, 0);
    set_en(0);
  endtask

  task automatic t_mod(input int n);
    apb_write(12'h008, ((n - 1) << 12) | 3 | (4 << 6));
    clear_track();
    set_en(1);
    for (int l = 0; l < n + 1; l++) run_line(l + 10);
    chk($sformatf("R7 MOD rises once for N=%0d", n), mod_rises, 1);
    chk($sformatf("R7 MOD after N SPS edges N=%0d", n), mod_at, n);
  endtask

  task automatic t_disable();
    @(posedge clk); #1 lcd_en = 0;
    @(negedge clk); #1 chk("R9 MOD low after disable", pan_mod, 0);
    repeat (3) @(posedge clk);
    clear_track(); set_en(1); run_line(20);
    chk("R9 count restarts after enable", mod_rises, 0);
    set_en(0);
  endtask

  task automatic t_force();
    apb_write(12'h008, 32'h3000 | 3 | (4 << 6));
    set_en(1);
    @(negedge clk); #1 chk("R8 MOD low before force", pan_mod, 0);
    apb_write(12'h004, 32'h1);
    @(negedge clk); #1 chk("R8 MOD forced high", pan_mod, 1);
    apb_write(12'h004, 32'h0);
    @(negedge clk); #1 chk("R8 MOD drops when force cleared", pan_mod, 0);
    set_en(0);
  endtask

  task automatic t_sample();
    apb_write(12'h008, 32'h1000 | 3 | (4 << 6));
    set_en(1); run_line(30);
    apb_write(12'h008, 32'h1000 | 5 | (2 << 6));
    run_line(31);
    check_shape("R10 live write has no effect", 0, 3, 4);
    set_en(0); set_en(1); run_line(32);
    check_shape("R10 new values after enable rise", 0, 5, 2);
    set_en(0);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1;
    t_reset();
    t_regs();
    t_reserved();
    t_bypass();
    t_retime();
    t_shapes();
    t_mod(2);
    t_disable();
    t_mod(1);
    set_en(0);
    t_mod(4);
    set_en(0);
    t_force();
    t_sample();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule